// File: doc/BRIEF.md
# ADC Result DMA Request Generator

This block raises DMA request pulses for a single group of ADC conversion results. Software programs one control word through a small synchronous register bus. The word selects how requests are paced. In per-result mode every stored result requests a transfer. In block mode one request is raised each time a programmed number of results has been stored. In group-end mode one request is raised when the whole conversion group has finished.

The converter signals its activity with two one-cycle strobes. One strobe marks a result written into the group result memory. The other marks that the group conversion sequence has completed. In block mode a down-counter is loaded with the programmed block count. Each result strobe decrements it, and a request fires on the step from 1 to 0, after which the counter reloads. The DMA request output is a registered pulse one clock long. The control word can be read back, with its unused bits returning zero.

Top module: `adc_dma_req_gen`

## Requirements
- R1: After reset the control word reads as 0x00000000 and `dma_req` is low.
- R2: The control word sits at byte address `CTRL_ADDR` (default 0x50). Its fields are block count in bits 24:16, group-end enable in bit 3, block enable in bit 2 and request enable in bit 0. All other bits read 0, so writing 0xFFFFFFFF reads back 0x01FF000D.
- R3: With group-end and block enables clear and request enable set, each `res_wr` strobe gives exactly one `dma_req` pulse, one cycle later.
- R4: With all three enables clear, no strobe produces a request.
- R5: With block enable set and group-end enable clear, a request fires on every Nth `res_wr` strobe, where N is the block count, and it repeats every N strobes. The request enable has no effect in this mode.
- R6: In block mode a block count of 0 never produces a request.
- R7: With group-end enable set, each `grp_done` strobe gives one `dma_req` pulse one cycle later. `res_wr` strobes and the request enable have no effect.
- R8: When group-end and block enables are both set, group-end behaviour applies and result strobes raise no request.
- R9: `dma_req` is high for exactly one clock per triggering strobe and never without a strobe in the previous cycle.
- R10: Every write to the control word reloads the block counter from the written count, so a partial block in progress is discarded.
- R11: Writes to any other address leave the control word unchanged, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| res_wr | input | 1 | One result stored in group memory |
| grp_done | input | 1 | Group conversion sequence complete |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
Every request is due on the clock edge that follows the strobe causing it. A register write takes effect for strobes in the next cycle, and read data is valid in the same cycle as the address. The bench drives stimulus at the falling edge and queues one expected request level per driven cycle, computed from its own model of the modes and the counter. A monitor compares that level against `dma_req` just after the next rising edge, and register readback is compared shortly after the address is applied.

// File: rtl/adcdma_pkg.sv
package adcdma_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 9;
    localparam int CNT_LO    = 16;
    localparam int CNT_HI    = CNT_LO + CNT_W - 1;
    localparam int GEND_BIT  = 3;
    localparam int BLK_BIT   = 2;
    localparam int REQ_BIT   = 0;

    typedef struct packed {
        logic [CNT_W-1:0] blk_cnt;
        logic             grp_end_en;
        logic             blk_en;
        logic             req_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_PER_RES = 2'd1,
        MODE_BLOCK   = 2'd2,
        MODE_GRP_END = 2'd3
    } mode_e;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.blk_cnt    = w[CNT_HI:CNT_LO];
        c.grp_end_en = w[GEND_BIT];
        c.blk_en     = w[BLK_BIT];
        c.req_en     = w[REQ_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w                = '0;
        w[CNT_HI:CNT_LO] = c.blk_cnt;
        w[GEND_BIT]      = c.grp_end_en;
        w[BLK_BIT]       = c.blk_en;
        w[REQ_BIT]       = c.req_en;
        return w;
    endfunction

endpackage

// File: rtl/adcdma_ctrl_reg.sv
module adcdma_ctrl_reg
    import adcdma_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic              ld_cnt,
    output logic [CNT_W-1:0]  ld_val
);

    typedef struct packed {
        ctrl_t ctrl;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d   = st_q;
        hit    = (bus_addr == CTRL_ADDR);
        ld_cnt = hit && bus_we;
        ld_val = bus_wdata[CNT_HI:CNT_LO];
        if (ld_cnt) begin
            st_d.ctrl = ctrl_unpack(bus_wdata);
        end
        bus_rdata = hit ? ctrl_pack(st_q.ctrl) : '0;
        ctrl      = st_q.ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adcdma_thr_cnt.sv
module adcdma_thr_cnt
    import adcdma_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         step,
    output logic         fire
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (step && (st_q.cnt != '0)) begin
            if (st_q.cnt == ONE) begin
                fire     = 1'b1;
                st_d.cnt = reload_val;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adcdma_req_sel.sv
module adcdma_req_sel
    import adcdma_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  res_wr,
    input  logic  grp_done,
    input  logic  blk_fire,
    output logic  blk_step,
    output logic  dma_req
);

    typedef struct packed {
        logic req;
    } sel_st_t;

    sel_st_t st_d, st_q;
    mode_e   mode;

    always_comb begin
        if (ctrl.grp_end_en)  mode = MODE_GRP_END;
        else if (ctrl.blk_en) mode = MODE_BLOCK;
        else if (ctrl.req_en) mode = MODE_PER_RES;
        else                  mode = MODE_OFF;

        blk_step = (mode == MODE_BLOCK) && res_wr;

        st_d = st_q;
        unique case (mode)
            MODE_GRP_END: st_d.req = grp_done;
            MODE_BLOCK:   st_d.req = blk_fire;
            MODE_PER_RES: st_d.req = res_wr;
            default:      st_d.req = 1'b0;
        endcase
        dma_req = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_dma_req_gen.sv
module adc_dma_req_gen
    import adcdma_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              res_wr,
    input  logic              grp_done,
    output logic              dma_req
);

    ctrl_t            ctrl_q;
    logic             ld_cnt;
    logic [CNT_W-1:0] ld_val;
    logic             blk_step;
    logic             blk_fire;

    adcdma_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl_q),
        .ld_cnt    (ld_cnt),
        .ld_val    (ld_val)
    );

    adcdma_thr_cnt #(
        .W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld_cnt),
        .load_val   (ld_val),
        .reload_val (ctrl_q.blk_cnt),
        .step       (blk_step),
        .fire       (blk_fire)
    );

    adcdma_req_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_q),
        .res_wr   (res_wr),
        .grp_done (grp_done),
        .blk_fire (blk_fire),
        .blk_step (blk_step),
        .dma_req  (dma_req)
    );

endmodule

// File: rtl/adcdma_chk.sv
module adcdma_chk
    import adcdma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        res_wr,
    input logic        grp_done,
    input logic        dma_req,
    input logic [31:0] bus_rdata,
    input ctrl_t       ctrl
);

    localparam logic [31:0] LIVE_MASK = 32'h01FF_000D;

    // R2: unused bits never read as one
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~LIVE_MASK) == 32'h0);

    // R3: per-result mode answers each result strobe
    p_per_res_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.grp_end_en && !ctrl.blk_en && ctrl.req_en && res_wr) |=> dma_req);

    // R6: empty block count stays silent
    p_zero_blk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.grp_end_en && ctrl.blk_en && ctrl.blk_cnt == '0) |=> !dma_req);

    // R7: group-end mode answers grp_done only
    p_grp_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.grp_end_en && grp_done) |=> dma_req);

    // R8: result strobes are silent when group-end is selected
    p_grp_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.grp_end_en && !grp_done) |=> !dma_req);

    // R9: no request without a strobe the cycle before
    p_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_wr && !grp_done) |=> !dma_req);

endmodule

bind adc_dma_req_gen adcdma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_wr    (res_wr),
    .grp_done  (grp_done),
    .dma_req   (dma_req),
    .bus_rdata (bus_rdata),
    .ctrl      (ctrl_q)
);

// File: tb/sim_adc_dma_req_gen.sv
`timescale 1ns/1ps
module sim_adc_dma_req_gen;

    localparam logic [7:0] CTRL_A = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        res_wr = 1'b0;
    logic        grp_done = 1'b0;
    logic        dma_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  v;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    string cur_tag = "R1";

    // bench model state
    logic [8:0] m_cnt = '0;
    logic [8:0] m_blk = '0;
    logic       m_gend = 1'b0, m_blken = 1'b0, m_reqen = 1'b0;

    always #4 clk = ~clk;

    adc_dma_req_gen u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .res_wr(res_wr),
        .grp_done(grp_done), .dma_req(dma_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one driven cycle: inputs at falling edge, expected level queued
    task automatic cyc(input logic r, input logic g, input logic we,
                       input logic [7:0] a, input logic [31:0] d);
        exp_t e;
        @(negedge clk);
        res_wr = r; grp_done = g; bus_we = we; bus_addr = a; bus_wdata = d;
        e.tag = cur_tag;
        if (m_gend)       e.v = g;
        else if (m_blken) e.v = r && (m_cnt == 9'd1);
        else              e.v = m_reqen && r;
        exp_q.push_back(e);
        if (we && a == CTRL_A) begin
            m_blk = d[24:16]; m_gend = d[3]; m_blken = d[2]; m_reqen = d[0];
            m_cnt = d[24:16];
        end else if (!m_gend && m_blken && r && m_cnt != 0) begin
            m_cnt = (m_cnt == 9'd1) ? m_blk : m_cnt - 9'd1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b0, 1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, 1'b0, 1'b0, a, 32'h0);
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic res(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h0, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h0, 32'h0);
    endtask

    // monitor: compare one queued level just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " dma_req"}, {31'h0, dma_req}, {31'h0, e.v});
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_tag = "R1";
        #1 check("R1 dma_req", {31'h0, dma_req}, 32'h0);
        rd(CTRL_A, 32'h0, "R1 ctrl");

        // R2 field layout and unused bits
        cur_tag = "R2";
        wr(CTRL_A, 32'hFFFF_FFF2);
        rd(CTRL_A, 32'h01FF_0000, "R2 partial");
        wr(CTRL_A, 32'hFFFF_FFFF);
        rd(CTRL_A, 32'h01FF_000D, "R2 all");

        // R11 other address ignored
        cur_tag = "R11";
        wr(8'h54, 32'h0);
        rd(CTRL_A, 32'h01FF_000D, "R11 keep");
        rd(8'h54, 32'h0, "R11 other");

        // R4 all enables off
        cur_tag = "R4";
        wr(CTRL_A, 32'h0005_0000);
        res(3); cyc(1'b0, 1'b1, 1'b0, 8'h0, 32'h0); idle(2);

        // R3 per-result
        cur_tag = "R3";
        wr(CTRL_A, 32'h0000_0001);
        res(3); idle(1); res(1); idle(2); cyc(1'b0, 1'b1, 1'b0, 8'h0, 32'h0); idle(1);

        // R5 block of 3, request enable set too
        cur_tag = "R5";
        wr(CTRL_A, 32'h0003_0005);
        res(7); idle(1); res(2); idle(2);
        // R5 block of 1
        wr(CTRL_A, 32'h0001_0004);
        res(3); idle(2);

        // R6 zero block count
        cur_tag = "R6";
        wr(CTRL_A, 32'h0000_0005);
        res(6); idle(2);

        // R10 reload on rewrite discards partial block
        cur_tag = "R10";
        wr(CTRL_A, 32'h0004_0004);
        res(2);
        wr(CTRL_A, 32'h0004_0004);
        res(4); idle(1); res(3); idle(2);

        // R7 group-end
        cur_tag = "R7";
        wr(CTRL_A, 32'h0000_0009);
        res(3);
        cyc(1'b0, 1'b1, 1'b0, 8'h0, 32'h0);
        idle(1);
        cyc(1'b1, 1'b1, 1'b0, 8'h0, 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 8'h0, 32'h0);
        idle(2);

        // R8 both enables, group-end wins
        cur_tag = "R8";
        wr(CTRL_A, 32'h0001_000C);
        res(4);
        cyc(1'b0, 1'b1, 1'b0, 8'h0, 32'h0);
        idle(2);

        // R9 pulse width: single strobe, then quiet
        cur_tag = "R9";
        wr(CTRL_A, 32'h0000_0001);
        res(1); idle(4);

        idle(2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule